// File: doc/BRIEF.md
# Stereo Linear Attenuator with Clear-on-Read Peak Meters

This block sits after the recording path's decimation and handles two 24-bit two's-complement sample streams, one for the left channel and one for the right. Each channel has its own 8-bit attenuation code. The code scales the sample linearly: every increment of the code removes 1/256 of full scale, so code 0 passes the sample through unchanged and code 255 leaves 1/256 of it. The scaled pair leaves through a register one clock after the input strobe, together with its own valid pulse.

Alongside the gain path, each channel keeps a running peak meter. The meter holds the largest input magnitude seen since it was last read, measured before any attenuation. A one-cycle read strobe with a channel select returns the selected meter on the next clock. The same read resets that meter to zero. If a sample arrives in the cycle of the read, the meter restarts from that sample's magnitude, so no peak falls between two reads.

Top module: `stereo_vol_peak`

## Requirements
- R1: After synchronous reset, `out_valid`, `rd_valid`, `out_left`, `out_right` and `rd_data` are zero, and both peak meters read back as zero.
- R2: `out_valid` pulses high exactly one clock after each cycle with `in_valid` high and is low otherwise. The output samples hold their last value when no strobe is present.
- R3: Each output equals floor(input × (256 − code) / 256), computed by an arithmetic shift. Code 0 gives the input unchanged.
- R4: Code 255 gives floor(input / 256). For example, −1 gives −1, 1 gives 0, and −8388608 gives −32768.
- R5: The left output uses only `vol_left` and the right output uses only `vol_right`.
- R6: Each peak meter holds the largest absolute input value (before attenuation) among the samples taken since its last read or reset.
- R7: The most negative input code (0x800000) counts as magnitude 0x7FFFFF.
- R8: A read is a one-cycle `rd_en` pulse, with `rd_sel` = 0 selecting left and 1 selecting right. One clock later `rd_valid` pulses and `rd_data` holds the meter value from the read cycle, zero-extended to 24 bits.
- R9: A read clears only the selected meter. The other meter keeps its value.
- R10: When a sample is taken in the same cycle as a read of a channel, the read returns that channel's value from before the sample, and the meter then holds the new sample's magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| vol_left | input | 8 | Left attenuation code |
| vol_right | input | 8 | Right attenuation code |
| rd_en | input | 1 | Peak read strobe |
| rd_sel | input | 1 | Meter select: 0 left, 1 right |
| out_valid | output | 1 | Scaled sample pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 24 | Peak magnitude read back |

## Verification
The sample update of a meter and the clearing read of that same meter can land in one clock. The bench provokes this by raising `in_valid` and `rd_en` in the same cycle while the meter already holds a larger value than the new sample. It then judges two things. First, the returned word must be the older, larger peak. Second, a following read must return the new sample's magnitude, not zero. The bench also drives a sample during a read of the opposite channel, to confirm that the unselected meter simply accumulates.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int NUM_CH  = 2;
  localparam int CH_LEFT = 0;
  localparam int CH_RGHT = 1;
endpackage

// File: rtl/vp_gain.sv
module vp_gain #(
  parameter int DATA_W = 24,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp,
  input  logic [STEP_W-1:0] atten,
  output logic              res_vld,
  output logic [DATA_W-1:0] res
);
  localparam int GAIN_W = STEP_W + 2;
  localparam int PROD_W = DATA_W + GAIN_W;
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << STEP_W;

  logic signed [GAIN_W-1:0] gain_s;
  logic signed [DATA_W-1:0] smp_s;
  logic signed [PROD_W-1:0] prod;
  logic        [DATA_W-1:0] res_n;

  assign gain_s = $signed(UNITY - {2'b00, atten});
  assign smp_s  = $signed(smp);
  assign prod   = smp_s * gain_s;
  // Dropping the low STEP_W bits of a signed product is a floor divide.
  assign res_n  = prod[STEP_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= smp_vld;
      if (smp_vld) res <= res_n;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> res_vld);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> (!res_vld && $stable(res)));
  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && atten == '0) |=> (res == $past(smp)));
endmodule

// File: rtl/vp_peak.sv
module vp_peak #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] smp,
  input  logic              clr,
  output logic [DATA_W-2:0] peak
);
  localparam logic [DATA_W-2:0] MAX_MAG = '1;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] negated;
  logic [DATA_W-2:0] mag;
  logic [DATA_W-2:0] peak_n;

  assign negated = ~smp + 1'b1;

  always_comb begin
    if (!smp[DATA_W-1])      mag = smp[DATA_W-2:0];
    else if (smp == MOST_NEG) mag = MAX_MAG;
    else                      mag = negated[DATA_W-2:0];
  end

  always_comb begin
    if (clr)                     peak_n = load ? mag : '0;
    else if (load && mag > peak) peak_n = mag;
    else                         peak_n = peak;
  end

  always_ff @(posedge clk) begin
    if (rst) peak <= '0;
    else     peak <= peak_n;
  end

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> (peak == '0));
  assert_peak_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (peak >= $past(peak)));
  assert_peak_covers_sample_R6: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (peak >= $past(mag)));
  assert_collide_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (load && clr) |=> (peak == $past(mag)));
endmodule

// File: rtl/vp_readport.sv
module vp_readport #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [DATA_W-2:0] peak_l,
  input  logic [DATA_W-2:0] peak_r,
  output logic              clr_l,
  output logic              clr_r,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-2:0] picked;

  assign clr_l  = rd_en && !rd_sel;
  assign clr_r  = rd_en &&  rd_sel;
  assign picked = rd_sel ? peak_r : peak_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= {1'b0, picked};
    end
  end

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_read_left_value_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_sel) |=> (rd_data == {1'b0, $past(peak_l)}));
  assert_read_right_value_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel) |=> (rd_data == {1'b0, $past(peak_r)}));
endmodule

// File: rtl/stereo_vol_peak.sv
module stereo_vol_peak #(
  parameter int DATA_W = 24,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [STEP_W-1:0] vol_left,
  input  logic [STEP_W-1:0] vol_right,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import svp_pkg::*;

  logic [DATA_W-1:0] smp_a  [NUM_CH];
  logic [STEP_W-1:0] step_a [NUM_CH];
  logic [DATA_W-1:0] res_a  [NUM_CH];
  logic              vld_a  [NUM_CH];
  logic [DATA_W-2:0] peak_a [NUM_CH];
  logic              clr_a  [NUM_CH];

  assign smp_a[CH_LEFT]  = in_left;
  assign smp_a[CH_RGHT]  = in_right;
  assign step_a[CH_LEFT] = vol_left;
  assign step_a[CH_RGHT] = vol_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vp_gain #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_gain (
      .clk(clk), .rst(rst), .smp_vld(in_valid), .smp(smp_a[c]),
      .atten(step_a[c]), .res_vld(vld_a[c]), .res(res_a[c]));

    vp_peak #(.DATA_W(DATA_W)) u_peak (
      .clk(clk), .rst(rst), .load(in_valid), .smp(smp_a[c]),
      .clr(clr_a[c]), .peak(peak_a[c]));
  end

  vp_readport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .peak_l(peak_a[CH_LEFT]), .peak_r(peak_a[CH_RGHT]),
    .clr_l(clr_a[CH_LEFT]), .clr_r(clr_a[CH_RGHT]),
    .rd_valid(rd_valid), .rd_data(rd_data));

  assign out_valid = vld_a[CH_LEFT];
  assign out_left  = res_a[CH_LEFT];
  assign out_right = res_a[CH_RGHT];

  assert_lanes_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    vld_a[CH_LEFT] == vld_a[CH_RGHT]);
  assert_single_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/stereo_vol_peak_bench.sv
module stereo_vol_peak_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [7:0] vol_left = '0, vol_right = '0;
  logic rd_en = 1'b0, rd_sel = 1'b0;
  logic out_valid, rd_valid;
  logic [23:0] out_left, out_right, rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stereo_vol_peak u_stereo_vol_peak (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .vol_left(vol_left), .vol_right(vol_right),
    .rd_en(rd_en), .rd_sel(rd_sel), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .rd_valid(rd_valid),
    .rd_data(rd_data));

  localparam int NV = 8;
  localparam logic [23:0] T_IL [NV] = '{24'd1000, 24'd256, 24'hFFFFFF, 24'h7FFFFF,
                                        24'h800000, 24'hFFFFFD, 24'd100, 24'd0};
  localparam logic [23:0] T_IR [NV] = '{24'hFFFC18, 24'hFFFF00, 24'd1, 24'h800000,
                                        24'd512, 24'd3, 24'hFFFF9C, 24'd0};
  localparam logic [7:0]  T_VL [NV] = '{8'd0, 8'd128, 8'd255, 8'd1, 8'd255, 8'd128, 8'd200, 8'd7};
  localparam logic [7:0]  T_VR [NV] = '{8'd0, 8'd128, 8'd255, 8'd0, 8'd64, 8'd128, 8'd200, 8'd3};
  localparam logic [23:0] T_OL [NV] = '{24'd1000, 24'd128, 24'hFFFFFF, 24'h7F7FFF,
                                        24'hFF8000, 24'hFFFFFE, 24'd21, 24'd0};
  localparam logic [23:0] T_OR [NV] = '{24'hFFFC18, 24'hFFFF80, 24'd0, 24'h800000,
                                        24'd384, 24'd1, 24'hFFFFEA, 24'd0};

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample(logic [23:0] l, logic [23:0] r, logic [7:0] vl, logic [7:0] vr,
                        logic [23:0] el, logic [23:0] er, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r; vol_left = vl; vol_right = vr;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {23'd0, out_valid}, 24'd1);
    chk({tag, " left"}, out_left, el);
    chk({tag, " right"}, out_right, er);
  endtask

  task automatic rd(logic sel, logic [23:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rd_valid"}, {23'd0, rd_valid}, 24'd1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", {23'd0, out_valid}, 24'd0);
    chk("R1 rd_valid", {23'd0, rd_valid}, 24'd0);
    chk("R1 out_left", out_left, 24'd0);
    chk("R1 out_right", out_right, 24'd0);
    chk("R1 rd_data", rd_data, 24'd0);
    rd(1'b0, 24'd0, "R1 left meter");
    rd(1'b1, 24'd0, "R1 right meter");

    // R3 R4 R5 R2: table walk
    for (int i = 0; i < NV; i++)
      sample(T_IL[i], T_IR[i], T_VL[i], T_VR[i], T_OL[i], T_OR[i], "R3/R4/R5 vec");

    // R2: nonzero output must hold with no strobe
    sample(24'd4096, 24'd8, 8'd0, 8'd0, 24'd4096, 24'd8, "R2 load");
    @(negedge clk);
    chk("R2 no strobe valid", {23'd0, out_valid}, 24'd0);
    chk("R2 hold left", out_left, 24'd4096);

    // R7: both meters saturated by most-negative / max codes
    rd(1'b0, 24'h7FFFFF, "R7 left peak");
    rd(1'b0, 24'd0, "R9 left cleared");
    rd(1'b1, 24'h7FFFFF, "R9 right untouched");
    rd(1'b1, 24'd0, "R9 right cleared");

    // R6: peak measured before attenuation
    sample(24'hFFEC78, 24'd20, 8'd255, 8'd255, 24'hFFFFEC, 24'd0, "R6 load");
    sample(24'd3000, 24'd5, 8'd0, 8'd0, 24'd3000, 24'd5, "R6 smaller");
    rd(1'b0, 24'd5000, "R6 left peak");

    // R10: sample in the cycle of a right read
    @(negedge clk);
    in_valid = 1'b1; in_left = 24'd77; in_right = 24'd7; vol_left = 8'd0; vol_right = 8'd0;
    rd_en = 1'b1; rd_sel = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0;
    chk("R10 returns old right", rd_data, 24'd20);
    rd(1'b1, 24'd7, "R10 right reloaded");
    rd(1'b0, 24'd77, "R10 other side accumulates");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule